// File: doc/BRIEF.md
# Video Encoder Operating-Mode Controller

This block keeps the run-time operating state of a video encoder. Software reaches it through a simple parallel register bus: an address, write data, a write strobe and combinational read data. It holds four 8-bit registers. The central one is the control register. The other three are a standard register, a power register and a timing-mode register, and the control register refers to each of them. From these registers and three input pins, the block decides four things: whether pixel data is blanked to black, which timing mode the timing generator runs in, whether the active standard is NTSC or PAL, and whether sleep is requested.

Out of reset, pixels are blanked and master timing is forced. This lasts until software sets the pixel-valid bit. The source of the standard is chosen by a bit in the control register: either the standard register or a dedicated pin. The source of sleep is chosen by the power register: either the control register's sleep bit or a pair of legacy pins. The blanking, timing-mode and sleep outputs are registered. The standard and pedestal outputs are combinational.

Register map (8-bit data). Standard register at 00h: bit 0 set means PAL. Control register at 02h: bit 7 is sleep, bit 6 is pixel-valid, bit 5 takes the standard from the register, and bit 3 enables the pedestal. Power register at 06h: bit 0 lets software control sleep. Timing-mode register at 0Ah: bits 1:0 hold the programmed timing mode. A timing-mode code of 00 means master.

Top module: `vmc_mode_ctrl`

## Requirements
- R1: A synchronous active-low reset clears all four registers to 00h, sets `pix_blank` to 1, sets `timing_mode` to 00 (master) and clears `sleep_req` to 0.
- R2: While control bit 6 is 0, `pix_blank` is 1 and `timing_mode` is 00. While control bit 6 is 1, `pix_blank` is 0 and `timing_mode` equals timing-mode register bits 1:0.
- R3: When control bit 5 is 1, `std_pal` equals standard register bit 0. When control bit 5 is 0, `std_pal` equals the `std_pin` input (1 = PAL).
- R4: When power register bit 0 is 1, `sleep_req` follows control bit 7, and the legacy pins have no effect.
- R5: When power register bit 0 is 0, `sleep_req` is 1 exactly when `slp_pin_a` and `slp_pin_b` are both 1, and control bit 7 has no effect.
- R6: While `sleep_req` is 1, every register still accepts writes and returns its value on reads.
- R7: While asleep under software control, writing control bit 7 as 0 clears `sleep_req`. Applying reset also clears it.
- R8: `pedestal_en` equals control bit 3 when the active standard is NTSC, and is 0 when the active standard is PAL.
- R9: A write to any address other than 00h, 02h, 06h or 0Ah changes no register, and a read of such an address returns 00h.
- R10: `rd_data` shows the addressed register in the same cycle, without a clock. `pix_blank`, `timing_mode` and `sleep_req` change on the first clock edge after the edge that loads the register causing the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| rd_data | output | 8 | Read data for `bus_addr`, combinational |
| std_pin | input | 1 | External standard select, 1 = PAL |
| slp_pin_a | input | 1 | Legacy sleep pin A |
| slp_pin_b | input | 1 | Legacy sleep pin B |
| pix_blank | output | 1 | 1 = replace pixel data with black |
| timing_mode | output | 2 | Effective timing mode, 00 = master |
| std_pal | output | 1 | Active standard, 1 = PAL |
| pedestal_en | output | 1 | Pedestal insertion enable |
| sleep_req | output | 1 | Sleep request to power control |

## Verification
Some rules are checked by assertions on every cycle: blanking always comes with master timing, the pedestal is never enabled under PAL, a write to an unmapped address leaves every register unchanged, and writing the sleep bit as 0 clears it on the next cycle. Other behaviour can only be shown by the bench's sweeps: the one-cycle lag of the registered outputs, the choice between register and pin as the source of the standard and of sleep across every combination of enables and pins, and register access while asleep followed by the two ways of waking.

// File: rtl/vmc_pkg.sv
// Package vmc_pkg
// Shared types and constants for the operating-mode controller.
// Assumes 8-bit registers. The field positions below are what the
// decision logic decodes.
package vmc_pkg;

    localparam int REG_W = 8;
    localparam int NREG  = 4;

    // Register slots in the register file
    localparam int SLOT_STD   = 0;
    localparam int SLOT_CTRL  = 1;
    localparam int SLOT_PWR   = 2;
    localparam int SLOT_TMODE = 3;

    localparam logic [1:0] TMODE_MASTER = 2'b00;

    // Control register layout
    typedef struct packed {
        logic       sleep;        // bit 7
        logic       pix_valid;    // bit 6
        logic       std_from_reg; // bit 5
        logic       spare4;       // bit 4
        logic       ped_on;       // bit 3
        logic [2:0] spare;        // bits 2:0
    } ctrl_t;

endpackage

// File: rtl/vmc_regfile.sv
// Module vmc_regfile
// Holds the four mode registers and decodes bus writes and reads.
// Assumes a single-cycle write strobe. A write or read to an
// unmapped address has no effect and reads back zero.
module vmc_regfile
    import vmc_pkg::*;
#(
    parameter int AW = 8,
    parameter logic [AW-1:0] ADDR_STD   = 'h00,
    parameter logic [AW-1:0] ADDR_CTRL  = 'h02,
    parameter logic [AW-1:0] ADDR_PWR   = 'h06,
    parameter logic [AW-1:0] ADDR_TMODE = 'h0A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic [REG_W-1:0] wdata,
    input  logic             wr,
    output logic [REG_W-1:0] rdata,
    output logic [REG_W-1:0] std_q,
    output logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] pwr_q,
    output logic [REG_W-1:0] tmode_q
);

    logic [AW-1:0]    addr_tab [NREG];
    logic [NREG-1:0]  hit;
    logic [REG_W-1:0] q [NREG];

    assign addr_tab[SLOT_STD]   = ADDR_STD;
    assign addr_tab[SLOT_CTRL]  = ADDR_CTRL;
    assign addr_tab[SLOT_PWR]   = ADDR_PWR;
    assign addr_tab[SLOT_TMODE] = ADDR_TMODE;

    // Address compare, one comparator per register slot
    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign hit[g] = (addr == addr_tab[g]);
    end

    // Register storage: clear on reset, load on a matching write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) q[i] <= '0;
        end else if (wr) begin
            for (int i = 0; i < NREG; i++)
                if (hit[i]) q[i] <= wdata;
        end
    end

    // Read multiplexer: OR of the selected slots, zero when nothing matches
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++)
            if (hit[i]) rdata = rdata | q[i];
    end

    assign std_q   = q[SLOT_STD];
    assign ctrl_q  = q[SLOT_CTRL];
    assign pwr_q   = q[SLOT_PWR];
    assign tmode_q = q[SLOT_TMODE];

    // R9
    ignored_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit == '0) |=> ($stable(std_q) && $stable(ctrl_q)
                               && $stable(pwr_q) && $stable(tmode_q)));

    // R7
    sleep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit[SLOT_CTRL] && !wdata[REG_W-1]) |=> !ctrl_q[REG_W-1]);

endmodule

// File: rtl/vmc_decide.sv
// Module vmc_decide
// Combinational decisions: the source of the standard, the pedestal
// gate, blanking, the forced timing mode and the source of sleep.
// Assumes the pins have already been synchronised by the caller.
module vmc_decide
    import vmc_pkg::*;
(
    input  logic [REG_W-1:0] std_q,
    input  logic [REG_W-1:0] ctrl_q,
    input  logic [REG_W-1:0] pwr_q,
    input  logic [REG_W-1:0] tmode_q,
    input  logic             std_pin,
    input  logic             slp_pin_a,
    input  logic             slp_pin_b,
    output logic             std_pal,
    output logic             ped_en,
    output logic             blank_d,
    output logic [1:0]       tmode_d,
    output logic             sleep_d
);

    ctrl_t c;
    assign c = ctrl_t'(ctrl_q);

    // Standard source: register field or external pin
    always_comb std_pal = c.std_from_reg ? std_q[0] : std_pin;

    // Pedestal only under NTSC
    always_comb ped_en = c.ped_on & ~std_pal;

    // Blanking and forced master timing until pixel data is valid
    always_comb begin
        blank_d = ~c.pix_valid;
        tmode_d = c.pix_valid ? tmode_q[1:0] : TMODE_MASTER;
    end

    // Sleep source: software bit when enabled, legacy pin pair otherwise
    always_comb sleep_d = pwr_q[0] ? c.sleep : (slp_pin_a & slp_pin_b);

endmodule

// File: rtl/vmc_outreg.sv
// Module vmc_outreg
// Output register stage for blanking, timing mode and sleep request.
// Assumes decisions arrive from combinational logic. The outputs
// change one clock after their inputs change.
module vmc_outreg
    import vmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blank_d,
    input  logic [1:0] tmode_d,
    input  logic       sleep_d,
    output logic       pix_blank,
    output logic [1:0] timing_mode,
    output logic       sleep_req
);

    // Capture decisions; reset state is blanked, master, awake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_blank   <= 1'b1;
            timing_mode <= TMODE_MASTER;
            sleep_req   <= 1'b0;
        end else begin
            pix_blank   <= blank_d;
            timing_mode <= tmode_d;
            sleep_req   <= sleep_d;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pix_blank && !sleep_req && timing_mode == TMODE_MASTER));

    // R2
    master_when_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_blank |-> timing_mode == TMODE_MASTER);

endmodule

// File: rtl/vmc_mode_ctrl.sv
// Module vmc_mode_ctrl (top)
// Operating-mode controller: register storage plus decision logic
// for blanking, timing mode, video standard, pedestal and sleep.
// Assumes a synchronous active-low reset and pins in the clk domain.
module vmc_mode_ctrl
    import vmc_pkg::*;
#(
    parameter int AW = 8,
    parameter logic [AW-1:0] ADDR_STD   = 'h00,
    parameter logic [AW-1:0] ADDR_CTRL  = 'h02,
    parameter logic [AW-1:0] ADDR_PWR   = 'h06,
    parameter logic [AW-1:0] ADDR_TMODE = 'h0A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic             bus_wr,
    output logic [REG_W-1:0] rd_data,
    input  logic             std_pin,
    input  logic             slp_pin_a,
    input  logic             slp_pin_b,
    output logic             pix_blank,
    output logic [1:0]       timing_mode,
    output logic             std_pal,
    output logic             pedestal_en,
    output logic             sleep_req
);

    logic [REG_W-1:0] std_q, ctrl_q, pwr_q, tmode_q;
    logic             blank_d, sleep_d;
    logic [1:0]       tmode_d;

    vmc_regfile #(
        .AW(AW), .ADDR_STD(ADDR_STD), .ADDR_CTRL(ADDR_CTRL),
        .ADDR_PWR(ADDR_PWR), .ADDR_TMODE(ADDR_TMODE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
        .wr(bus_wr), .rdata(rd_data), .std_q(std_q), .ctrl_q(ctrl_q),
        .pwr_q(pwr_q), .tmode_q(tmode_q)
    );

    vmc_decide u_decide (
        .std_q(std_q), .ctrl_q(ctrl_q), .pwr_q(pwr_q), .tmode_q(tmode_q),
        .std_pin(std_pin), .slp_pin_a(slp_pin_a), .slp_pin_b(slp_pin_b),
        .std_pal(std_pal), .ped_en(pedestal_en), .blank_d(blank_d),
        .tmode_d(tmode_d), .sleep_d(sleep_d)
    );

    vmc_outreg u_out (
        .clk(clk), .rst_n(rst_n), .blank_d(blank_d), .tmode_d(tmode_d),
        .sleep_d(sleep_d), .pix_blank(pix_blank), .timing_mode(timing_mode),
        .sleep_req(sleep_req)
    );

    // R8
    pedestal_pal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        std_pal |-> !pedestal_en);

endmodule

// File: tb/test_vmc_mode_ctrl.sv
module test_vmc_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] rd_data;
    logic       std_pin = 1'b0, slp_pin_a = 1'b0, slp_pin_b = 1'b0;
    logic       pix_blank, std_pal, pedestal_en, sleep_req;
    logic [1:0] timing_mode;

    int checks = 0;
    int failures = 0;

    localparam logic [7:0] A_STD = 8'h00, A_CTRL = 8'h02, A_PWR = 8'h06, A_TM = 8'h0A;

    always #2 clk = ~clk;

    vmc_mode_ctrl i_vmc_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .rd_data(rd_data), .std_pin(std_pin),
        .slp_pin_a(slp_pin_a), .slp_pin_b(slp_pin_b), .pix_blank(pix_blank),
        .timing_mode(timing_mode), .std_pal(std_pal), .pedestal_en(pedestal_en),
        .sleep_req(sleep_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] r;
        @(negedge clk);
        do_reset();
        // R1: reset state
        check("R1 blank", {7'b0, pix_blank}, 8'h01);
        check("R1 sleep", {7'b0, sleep_req}, 8'h00);
        check("R1 tmode", {6'b0, timing_mode}, 8'h00);
        rd(A_STD, r);  check("R1 std reg", r, 8'h00);
        rd(A_CTRL, r); check("R1 ctrl reg", r, 8'h00);
        rd(A_PWR, r);  check("R1 pwr reg", r, 8'h00);
        rd(A_TM, r);   check("R1 tmode reg", r, 8'h00);

        // R10: registered latency of blanking and timing mode
        wr(A_TM, 8'h03);
        wr(A_CTRL, 8'h40);
        check("R10 blank holds one cycle", {7'b0, pix_blank}, 8'h01);
        tick();
        check("R10 blank after one cycle", {7'b0, pix_blank}, 8'h00);
        check("R10 tmode after one cycle", {6'b0, timing_mode}, 8'h03);

        // R2 R3 R8: sweep valid, std source, pedestal, std bit, pin, tmode
        for (int k = 0; k < 64; k++) begin
            logic valid, ssel, ped, sbit, pin;
            logic [1:0] tm;
            logic exp_pal;
            valid = k[0]; ssel = k[1]; ped = k[2]; sbit = k[3]; pin = k[4];
            tm = {k[5], ~k[0]};
            std_pin = pin;
            wr(A_STD, {7'b0, sbit});
            wr(A_TM, {6'b0, tm});
            wr(A_CTRL, {1'b0, valid, ssel, 1'b0, ped, 3'b0});
            tick();
            exp_pal = ssel ? sbit : pin;
            check("R2 blank", {7'b0, pix_blank}, {7'b0, ~valid});
            check("R2 tmode", {6'b0, timing_mode}, valid ? {6'b0, tm} : 8'h00);
            check("R3 std_pal", {7'b0, std_pal}, {7'b0, exp_pal});
            check("R8 pedestal", {7'b0, pedestal_en}, {7'b0, ped & ~exp_pal});
            rd(A_CTRL, r);
            check("R10 ctrl readback", r, {1'b0, valid, ssel, 1'b0, ped, 3'b0});
        end

        // R4 R5: sleep source sweep
        for (int k = 0; k < 16; k++) begin
            logic en, sb, pa, pb;
            en = k[0]; sb = k[1]; pa = k[2]; pb = k[3];
            slp_pin_a = pa; slp_pin_b = pb;
            wr(A_PWR, {7'b0, en});
            wr(A_CTRL, {sb, 7'h40});
            tick();
            if (en) check("R4 sleep from bit", {7'b0, sleep_req}, {7'b0, sb});
            else    check("R5 sleep from pins", {7'b0, sleep_req}, {7'b0, pa & pb});
        end

        // R6: registers accessible while asleep
        slp_pin_a = 1'b0; slp_pin_b = 1'b0;
        wr(A_PWR, 8'h01);
        wr(A_CTRL, 8'hC0);
        tick();
        check("R6 asleep", {7'b0, sleep_req}, 8'h01);
        wr(A_TM, 8'h5A);
        rd(A_TM, r);  check("R6 write while asleep", r, 8'h5A);
        wr(A_STD, 8'hA5);
        rd(A_STD, r); check("R6 write while asleep std", r, 8'hA5);
        check("R6 still asleep", {7'b0, sleep_req}, 8'h01);

        // R7: wake by writing 0
        wr(A_CTRL, 8'h40);
        tick();
        check("R7 wake by write", {7'b0, sleep_req}, 8'h00);
        // R7: wake by reset
        wr(A_CTRL, 8'hC0);
        tick();
        check("R7 asleep again", {7'b0, sleep_req}, 8'h01);
        do_reset();
        check("R7 wake by reset", {7'b0, sleep_req}, 8'h00);
        rd(A_CTRL, r); check("R7 ctrl cleared by reset", r, 8'h00);

        // R9: unmapped addresses ignored and read zero
        wr(A_STD, 8'h11); wr(A_CTRL, 8'h28); wr(A_PWR, 8'h01); wr(A_TM, 8'h02);
        for (int a = 0; a < 256; a++) begin
            if (a != 0 && a != 2 && a != 6 && a != 10) begin
                wr(8'(a), 8'hFF);
                rd(8'(a), r);
                check("R9 unmapped reads zero", r, 8'h00);
            end
        end
        rd(A_STD, r);  check("R9 std untouched", r, 8'h11);
        rd(A_CTRL, r); check("R9 ctrl untouched", r, 8'h28);
        rd(A_PWR, r);  check("R9 pwr untouched", r, 8'h01);
        rd(A_TM, r);   check("R9 tmode untouched", r, 8'h02);
        check("R9 sleep unaffected", {7'b0, sleep_req}, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule